// File: doc/BRIEF.md
# Two-Level Priority Interrupt Controller

This block collects a vector of interrupt sources and tells a processor whether to take an interrupt and which entry address to fetch. Every source has three software-visible bits: a pending flag, an individual enable and a level select. Raw event inputs arrive asynchronously. The block synchronizes them and detects their rising edges. Each detected edge latches the source's flag, which stays set until software clears it.

Two global enable bits, A and B, gate the requests. Their meaning depends on a mode bit. In single-level mode, A is the master enable. B additionally gates the sources that are configured as peripheral sources, and every request targets entry 0x0008. In two-level mode, A enables the upper level and B enables the lower level, with B effective only while A is set. Upper-level requests target 0x0008 and lower-level requests target 0x0018.

When the processor accepts a request, the block clears the global bit that belongs to the accepted level and records that level as active. When the processor returns, the block sets that global bit again. This arrangement lets an upper-level request preempt a lower-level handler, one level deep.

Top module: `irq_prio_ctrl`

## Requirements
- R1: A rising edge on `evtIn[i]` sets `flagsOut[i]` on the third rising clock edge after the input changes. The flag is set whatever the state of the enables, the level bits and the global bits. It stays set until it is cleared.
- R2: A 1 in `flagClr[i]` clears flag i at the next clock edge. If a detected event for the same source lands on that same edge, the flag stays set.
- R3: With the mode bit at 0, the level bits have no effect.
  - Sources below `NUM_CORE` request when their flag, their enable and A are all set.
  - The remaining sources also need B.
  - The vector is 0x0008.
- R4: With the mode bit at 1, a source whose level bit is 1 requests when its flag, its enable and A are set, and gets vector 0x0008. A source whose level bit is 0 also needs B, and gets vector 0x0018. When both levels request, 0x0008 is given. With no request, `irqVector` is 0x0000.
- R5: Source 0 is always upper level in two-level mode, whatever value its level bit holds.
- R6: An accepted request clears a global bit. An upper-level accept, or any accept in single-level mode, clears A. A lower-level accept clears B. `cpuAck` with no request pending changes nothing.
- R7: While a lower-level handler runs (B cleared), an upper-level request is still issued. While an upper-level handler runs (A cleared), no request of either level is issued.
- R8: On `cpuRet`, A is set and the upper-level active mark is cleared if that mark was set. Otherwise, if the lower level is active, B is set and its mark is cleared. With neither level active, `cpuRet` sets A.
- R9: After reset, all flags, enables and level bits are 0, A, B and the mode bit are 0, and `irqRequest` is 0.
- R10: A control write (`ctrlWe`) in the same cycle as an accepted request or a return is discarded. Control data is bit 0 = A, bit 1 = B, bit 2 = mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| evtIn | input | NUM_SRC | Raw asynchronous event lines |
| flagClr | input | NUM_SRC | Per-source flag clear mask |
| enWe | input | 1 | Write strobe for the enable vector |
| enData | input | NUM_SRC | New enable vector |
| prioWe | input | 1 | Write strobe for the level vector |
| prioData | input | NUM_SRC | New level vector (1 = upper) |
| ctrlWe | input | 1 | Write strobe for the control bits |
| ctrlData | input | 3 | {mode, B, A} |
| cpuAck | input | 1 | Processor accepts the current request |
| cpuRet | input | 1 | Processor returns from a handler |
| irqRequest | output | 1 | Interrupt request to the processor |
| irqVector | output | 16 | Entry address of the request, 0 when idle |
| flagsOut | output | NUM_SRC | Pending flags |
| globAOut | output | 1 | Global bit A |
| globBOut | output | 1 | Global bit B |

## Verification
The bench builds the block with eight sources, of which four are core sources (`NUM_CORE` = 4). This puts both source classes in reach of single-level gating, and lets every source-class and level combination occur within one byte of stimulus. It also leaves room for source 0 to hold its level bit at 0 in two-level mode while a genuine lower-level source fires. The bench covers the full accept/preempt/return chain, in which the lower-level handler is interrupted by an upper-level request and the two global bits are restored in the reverse order.

// File: rtl/irqc_pkg.sv
package irqc_pkg;

  typedef struct packed {
    logic clrA;
    logic setA;
    logic clrB;
    logic setB;
  } glbStrobe_t;

  localparam int VEC_W = 16;
  localparam logic [VEC_W-1:0] VEC_UPPER = 16'h0008;
  localparam logic [VEC_W-1:0] VEC_LOWER = 16'h0018;
  localparam logic [VEC_W-1:0] VEC_IDLE  = 16'h0000;

endpackage

// File: rtl/irqc_sync.sv
module irqc_sync #(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [WIDTH-1:0] rawIn,
  output logic [WIDTH-1:0] risePulse
);
  logic [WIDTH-1:0] meta, stable, prevQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      meta   <= '0;
      stable <= '0;
      prevQ  <= '0;
    end else begin
      meta   <= rawIn;
      stable <= meta;
      prevQ  <= stable;
    end
  end

  assign risePulse = stable & ~prevQ;
endmodule

// File: rtl/irqc_datapath.sv
module irqc_datapath
  import irqc_pkg::*;
#(
  parameter int NUM_SRC  = 8,
  parameter int NUM_CORE = 4
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [NUM_SRC-1:0] evtPulse,
  input  logic [NUM_SRC-1:0] flagClr,
  input  logic               enWe,
  input  logic [NUM_SRC-1:0] enData,
  input  logic               prioWe,
  input  logic [NUM_SRC-1:0] prioData,
  input  logic               ctrlWe,
  input  logic [2:0]         ctrlData,
  input  glbStrobe_t         strobe,
  output logic [NUM_SRC-1:0] flagsQ,
  output logic               globA,
  output logic               globB,
  output logic               modePrio,
  output logic               hiReq,
  output logic               loReq
);
  localparam logic [NUM_SRC-1:0] SRC0_BIT = NUM_SRC'(1);

  logic [NUM_SRC-1:0] enQ, prioQ, coreMask, prioEff, pend;
  logic anyStrobe, hiLegacy, hiLevel, loLevel;

  for (genvar i = 0; i < NUM_SRC; i++) begin : g_class
    assign coreMask[i] = (i < NUM_CORE);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      flagsQ <= '0;
      enQ    <= '0;
      prioQ  <= '0;
    end else begin
      flagsQ <= (flagsQ & ~flagClr) | evtPulse;
      if (enWe)   enQ   <= enData;
      if (prioWe) prioQ <= prioData;
    end
  end

  assign anyStrobe = strobe.clrA | strobe.setA | strobe.clrB | strobe.setB;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      globA    <= 1'b0;
      globB    <= 1'b0;
      modePrio <= 1'b0;
    end else if (anyStrobe) begin
      if (strobe.clrA)      globA <= 1'b0;
      else if (strobe.setA) globA <= 1'b1;
      if (strobe.clrB)      globB <= 1'b0;
      else if (strobe.setB) globB <= 1'b1;
    end else if (ctrlWe) begin
      {modePrio, globB, globA} <= ctrlData;
    end
  end

  assign prioEff  = prioQ | SRC0_BIT;
  assign pend     = flagsQ & enQ;
  assign hiLegacy = globA & ((|(pend & coreMask)) | (globB & |(pend & ~coreMask)));
  assign hiLevel  = globA & |(pend & prioEff);
  assign loLevel  = globA & globB & |(pend & ~prioEff);
  assign hiReq    = modePrio ? hiLevel : hiLegacy;
  assign loReq    = modePrio & loLevel;
endmodule

// File: rtl/irqc_control.sv
module irqc_control
  import irqc_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic             hiReq,
  input  logic             loReq,
  input  logic             cpuAck,
  input  logic             cpuRet,
  output glbStrobe_t       strobe,
  output logic             irqRequest,
  output logic [VEC_W-1:0] irqVector
);
  logic hiActive, loActive, takeHi, takeLo, retGo;

  assign takeHi = cpuAck & hiReq;
  assign takeLo = cpuAck & ~hiReq & loReq;
  assign retGo  = cpuRet & ~takeHi & ~takeLo;

  always_comb begin
    strobe      = '0;
    strobe.clrA = takeHi;
    strobe.clrB = takeLo;
    strobe.setA = retGo & (hiActive | ~loActive);
    strobe.setB = retGo & ~hiActive & loActive;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      hiActive <= 1'b0;
      loActive <= 1'b0;
    end else if (takeHi) begin
      hiActive <= 1'b1;
    end else if (takeLo) begin
      loActive <= 1'b1;
    end else if (retGo) begin
      if (hiActive) hiActive <= 1'b0;
      else          loActive <= 1'b0;
    end
  end

  assign irqRequest = hiReq | loReq;
  assign irqVector  = hiReq ? VEC_UPPER : (loReq ? VEC_LOWER : VEC_IDLE);
endmodule

// File: rtl/irq_prio_ctrl.sv
module irq_prio_ctrl
  import irqc_pkg::*;
#(
  parameter int NUM_SRC  = 8,
  parameter int NUM_CORE = 4
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [NUM_SRC-1:0] evtIn,
  input  logic [NUM_SRC-1:0] flagClr,
  input  logic               enWe,
  input  logic [NUM_SRC-1:0] enData,
  input  logic               prioWe,
  input  logic [NUM_SRC-1:0] prioData,
  input  logic               ctrlWe,
  input  logic [2:0]         ctrlData,
  input  logic               cpuAck,
  input  logic               cpuRet,
  output logic               irqRequest,
  output logic [15:0]        irqVector,
  output logic [NUM_SRC-1:0] flagsOut,
  output logic               globAOut,
  output logic               globBOut
);
  logic [NUM_SRC-1:0] evtPulse;
  glbStrobe_t strobe;
  logic hiReq, loReq, modeQ;

  irqc_sync #(.WIDTH(NUM_SRC)) u_sync (
    .clk(clk), .rstN(rstN), .rawIn(evtIn), .risePulse(evtPulse)
  );

  irqc_datapath #(.NUM_SRC(NUM_SRC), .NUM_CORE(NUM_CORE)) u_dp (
    .clk(clk), .rstN(rstN), .evtPulse(evtPulse), .flagClr(flagClr),
    .enWe(enWe), .enData(enData), .prioWe(prioWe), .prioData(prioData),
    .ctrlWe(ctrlWe), .ctrlData(ctrlData), .strobe(strobe),
    .flagsQ(flagsOut), .globA(globAOut), .globB(globBOut),
    .modePrio(modeQ), .hiReq(hiReq), .loReq(loReq)
  );

  irqc_control u_ctl (
    .clk(clk), .rstN(rstN), .hiReq(hiReq), .loReq(loReq),
    .cpuAck(cpuAck), .cpuRet(cpuRet), .strobe(strobe),
    .irqRequest(irqRequest), .irqVector(irqVector)
  );
endmodule

// File: rtl/irq_prio_ctrl_chk.sv
module irq_prio_ctrl_chk
  import irqc_pkg::*;
#(
  parameter int NUM_SRC = 8
) (
  input logic               clk,
  input logic               rstN,
  input logic               irqRequest,
  input logic [15:0]        irqVector,
  input logic [NUM_SRC-1:0] flagsOut,
  input logic [NUM_SRC-1:0] flagClr,
  input logic               globAOut,
  input logic               globBOut,
  input logic               modeQ,
  input logic               cpuAck
);
  a_r3_single_level_vector: assert property (@(posedge clk) disable iff (!rstN)
    (irqRequest && !modeQ) |-> irqVector == VEC_UPPER);

  a_r4_idle_vector: assert property (@(posedge clk) disable iff (!rstN)
    !irqRequest |-> irqVector == VEC_IDLE);

  a_r4_request_needs_a: assert property (@(posedge clk) disable iff (!rstN)
    irqRequest |-> globAOut);

  a_r7_lower_needs_both: assert property (@(posedge clk) disable iff (!rstN)
    (irqVector == VEC_LOWER) |-> (globAOut && globBOut && modeQ));

  a_r6_upper_accept_clears_a: assert property (@(posedge clk) disable iff (!rstN)
    (cpuAck && irqVector == VEC_UPPER) |=> !globAOut);

  a_r6_lower_accept_clears_b: assert property (@(posedge clk) disable iff (!rstN)
    (cpuAck && irqVector == VEC_LOWER) |=> (!globBOut && globAOut));

  a_r1_flags_hold: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> ((flagsOut & $past(flagsOut & ~flagClr)) == $past(flagsOut & ~flagClr)));
endmodule

bind irq_prio_ctrl irq_prio_ctrl_chk #(.NUM_SRC(NUM_SRC)) u_chk (
  .clk(clk), .rstN(rstN), .irqRequest(irqRequest), .irqVector(irqVector),
  .flagsOut(flagsOut), .flagClr(flagClr), .globAOut(globAOut),
  .globBOut(globBOut), .modeQ(modeQ), .cpuAck(cpuAck)
);

// File: tb/irq_prio_ctrl_tb.sv
`timescale 1ns/1ps
module irq_prio_ctrl_tb;
  localparam int N = 8;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [N-1:0] evtIn = '0, flagClr = '0, enData = '0, prioData = '0;
  logic enWe = 0, prioWe = 0, ctrlWe = 0, cpuAck = 0, cpuRet = 0;
  logic [2:0] ctrlData = '0;
  logic irqRequest, globAOut, globBOut;
  logic [15:0] irqVector;
  logic [N-1:0] flagsOut;
  int checks = 0, failures = 0;

  always #4 clk = ~clk;

  irq_prio_ctrl #(.NUM_SRC(N), .NUM_CORE(4)) u_dut (
    .clk(clk), .rstN(rstN), .evtIn(evtIn), .flagClr(flagClr),
    .enWe(enWe), .enData(enData), .prioWe(prioWe), .prioData(prioData),
    .ctrlWe(ctrlWe), .ctrlData(ctrlData), .cpuAck(cpuAck), .cpuRet(cpuRet),
    .irqRequest(irqRequest), .irqVector(irqVector), .flagsOut(flagsOut),
    .globAOut(globAOut), .globBOut(globBOut)
  );

  typedef struct packed {
    logic [2:0]   ctrl;   // {mode, B, A}
    logic [N-1:0] en;
    logic [N-1:0] prio;
    logic [N-1:0] evt;
    logic         req;
    logic [15:0]  vec;
  } vec_t;

  localparam vec_t TABLE [12] = '{
    '{3'b001, 8'hFF, 8'h00, 8'h02, 1'b1, 16'h0008}, // R3 core source, A only
    '{3'b001, 8'hFF, 8'h00, 8'h10, 1'b0, 16'h0000}, // R3 peripheral needs B
    '{3'b011, 8'hFF, 8'h00, 8'h10, 1'b1, 16'h0008}, // R3 peripheral with A,B
    '{3'b010, 8'hFF, 8'h00, 8'h01, 1'b0, 16'h0000}, // R3 A clear masks all
    '{3'b011, 8'hFF, 8'h00, 8'h20, 1'b1, 16'h0008}, // R3 level bits ignored
    '{3'b001, 8'hFD, 8'h00, 8'h02, 1'b0, 16'h0000}, // R3 enable gates
    '{3'b101, 8'hFF, 8'h04, 8'h04, 1'b1, 16'h0008}, // R4 upper level
    '{3'b101, 8'hFF, 8'h00, 8'h08, 1'b0, 16'h0000}, // R4 lower needs B
    '{3'b111, 8'hFF, 8'h00, 8'h08, 1'b1, 16'h0018}, // R4 lower level
    '{3'b110, 8'hFF, 8'hFF, 8'h04, 1'b0, 16'h0000}, // R4 A clear masks all
    '{3'b111, 8'hFF, 8'h00, 8'h01, 1'b1, 16'h0008}, // R5 source 0 upper
    '{3'b111, 8'hFF, 8'h10, 8'h12, 1'b1, 16'h0008}  // R4 upper wins
  };

  task automatic tick(int n = 1);
    repeat (n) begin
      @(posedge clk);
      @(negedge clk);
    end
  endtask

  task automatic check(string tag, logic [15:0] got, logic [15:0] exp);
    checks++;
    if (got !== exp) begin
      failures++;
      $display("FAIL %s got=%h expected=%h", tag, got, exp);
    end
  endtask

  task automatic pulseEvt(logic [N-1:0] m);
    evtIn = m;
    tick(2);
    evtIn = '0;
    tick(3);
  endtask

  task automatic writeCtrl(logic [2:0] d);
    ctrlWe = 1; ctrlData = d;
    tick();
    ctrlWe = 0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    @(negedge clk);
    tick(2);
    check("R9 request", {15'd0, irqRequest}, 16'd0);
    check("R9 flags", {8'd0, flagsOut}, 16'd0);
    check("R9 globals", {14'd0, globBOut, globAOut}, 16'd0);
    rstN = 1;
    tick();

    for (int i = 0; i < 12; i++) begin
      flagClr = '1; enWe = 1; enData = TABLE[i].en;
      prioWe = 1; prioData = TABLE[i].prio;
      ctrlWe = 1; ctrlData = TABLE[i].ctrl;
      tick();
      flagClr = '0; enWe = 0; prioWe = 0; ctrlWe = 0;
      pulseEvt(TABLE[i].evt);
      check($sformatf("R1 table %0d flags", i), {8'd0, flagsOut}, {8'd0, TABLE[i].evt});
      check($sformatf("R3/R4 table %0d request", i), {15'd0, irqRequest}, {15'd0, TABLE[i].req});
      check($sformatf("R3/R4 table %0d vector", i), irqVector, TABLE[i].vec);
    end

    // R1 latency: set on third edge
    flagClr = '1; tick(); flagClr = '0;
    evtIn = 8'h08;
    tick(2);
    check("R1 not yet set", {15'd0, flagsOut[3]}, 16'd0);
    tick();
    check("R1 set on third edge", {15'd0, flagsOut[3]}, 16'd1);
    evtIn = '0;
    tick(3);
    check("R1 held", {15'd0, flagsOut[3]}, 16'd1);

    // R2 set wins over clear
    evtIn = 8'h10;
    tick(2);
    flagClr = 8'h10;
    tick();
    flagClr = '0;
    check("R2 set wins", {15'd0, flagsOut[4]}, 16'd1);
    flagClr = 8'h18; tick(); flagClr = '0;
    check("R2 clear", {8'd0, flagsOut}, 16'd0);
    evtIn = '0; tick(2);

    // preempt / return chain in two-level mode
    enWe = 1; enData = '1; prioWe = 1; prioData = '0; tick(); enWe = 0; prioWe = 0;
    writeCtrl(3'b111);
    pulseEvt(8'h20);
    check("R4 lower vector", irqVector, 16'h0018);
    cpuAck = 1; tick(); cpuAck = 0;
    check("R6 lower accept clears B", {14'd0, globBOut, globAOut}, 16'b01);
    check("R6 no request after lower accept", {15'd0, irqRequest}, 16'd0);
    prioWe = 1; prioData = 8'h02; tick(); prioWe = 0;
    pulseEvt(8'h02);
    check("R7 upper preempts lower", irqVector, 16'h0008);
    cpuAck = 1; tick(); cpuAck = 0;
    check("R6 upper accept clears A", {14'd0, globBOut, globAOut}, 16'b00);
    check("R7 blocked in upper handler", {15'd0, irqRequest}, 16'd0);
    flagClr = 8'h02; tick(); flagClr = '0;
    cpuRet = 1; tick(); cpuRet = 0;
    check("R8 return restores A", {14'd0, globBOut, globAOut}, 16'b01);
    cpuRet = 1; tick(); cpuRet = 0;
    check("R8 return restores B", {14'd0, globBOut, globAOut}, 16'b11);
    check("R8 lower pending again", irqVector, 16'h0018);
    cpuAck = 1; ctrlWe = 1; ctrlData = 3'b000; tick(); cpuAck = 0; ctrlWe = 0;
    check("R10 write dropped on accept", {14'd0, globBOut, globAOut}, 16'b01);
    cpuAck = 1; tick(); cpuAck = 0;
    check("R6 ack without request", {14'd0, globBOut, globAOut}, 16'b01);
    cpuRet = 1; tick(); cpuRet = 0;
    check("R8 lower return", {14'd0, globBOut, globAOut}, 16'b11);

    // single-level mode
    writeCtrl(3'b000);
    cpuRet = 1; tick(); cpuRet = 0;
    check("R8 idle return sets A", {14'd0, globBOut, globAOut}, 16'b01);
    check("R3 peripheral held by B", {15'd0, irqRequest}, 16'd0);
    writeCtrl(3'b011);
    check("R3 peripheral vector", irqVector, 16'h0008);
    cpuAck = 1; tick(); cpuAck = 0;
    check("R6 single-level accept clears A", {14'd0, globBOut, globAOut}, 16'b10);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule